// File: doc/BRIEF.md
# Split Two-Way Address Translation Cache

This block is a small translation cache that sits in front of a page-table walker. It holds two independent arrays: one serves instruction fetches, the other serves all data accesses. Each array has 64 sets of two ways. The set is picked by virtual address bits [17:12]. A way stores a tag, the page-aligned physical address and the full page-table-entry word. There is no valid flag: a way is empty when its tag holds the reserved all-ones value, which no real tag can equal.

A lookup carries a virtual address and an access kind. One clock later the block reports a hit flag and the translated address. The walker, or the bench standing in for it, installs translations with a refill. A refill carries the virtual address, the page-table-entry word and the real page number. An invalidate command empties one set in both arrays. Each set has a single recency bit. This bit steers where a refill lands and is moved by ordinary hits.

A data write that hits an entry whose changed bit is still clear is reported as a miss. The block sets the bit in the stored entry in the same cycle. The walker can then mark the page dirty in memory, and the next write to that page hits.

Top module: `split_tlb`

## Requirements
- R1: After synchronous reset, every way in both arrays is empty and every recency bit is 0, so every lookup misses and the first refill into any set lands in way 0.
- R2: The result is registered. `hit_valid` equals the previous cycle's `lk_valid`. A missed or absent lookup gives `hit`=0 and `hit_paddr`=0.
- R3: The tag is `vaddr >> 12` and the set is `vaddr[17:12]`. A hit returns the stored page address ORed with `vaddr[11:0]`. An address with the same set but a different tag misses.
- R4: Access kind encoding: 0 instruction fetch, 1 data read, 2 data write, 3 probe. Kind 0 uses only the instruction array; kinds 1, 2 and 3 use only the data array. This applies to both lookups and refills.
- R5: A refill goes to way 1 when the set's recency bit is 0 and way 0 holds a valid tag, and to way 0 otherwise. The recency bit then names the chosen way. The refill stores `rpn << 12` as the page address, the full entry word and the tag.
- R6: A lookup hit of kind 0, 1 or 2 sets the recency bit to the hitting way. A probe hit (kind 3) leaves the recency bit unchanged.
- R7: A data write (kind 2) that hits an entry whose changed bit (bit `CHG_BIT`, default 7, of the entry word) is 0 reports a miss and sets that bit, leaving recency unchanged. A later write to the same page hits. Read hits ignore the changed bit.
- R8: A refill of kind 3 (probe) has no effect.
- R9: An invalidate empties both ways of the set `inv_vaddr[17:12]`, in both arrays.
- R10: When a refill and an invalidate hit the same set in one cycle, the invalidate wins. A lookup sees the array state from before any update made in its own cycle.
- R11: When both ways of a set hold the same tag, way 0's address is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup request |
| lk_kind | input | 2 | Lookup access kind |
| lk_vaddr | input | 32 | Lookup virtual address |
| rf_valid | input | 1 | Refill request |
| rf_kind | input | 2 | Access kind that caused the refill |
| rf_vaddr | input | 32 | Virtual address being installed |
| rf_pte | input | 32 | Page-table-entry word to store |
| rf_rpn | input | 20 | Real page number |
| inv_valid | input | 1 | Invalidate request |
| inv_vaddr | input | 32 | Address whose set is emptied |
| hit_valid | output | 1 | Registered: a lookup was made last cycle |
| hit | output | 1 | Registered: that lookup hit |
| hit_paddr | output | 32 | Registered physical address, 0 on a miss |

## Verification
The bench builds the block with its default parameters: 4 KiB pages, 64 sets and the changed bit at position 7. With these values, addresses that differ only above bit 17 fall into the same set with different tags. This makes eviction order, recency steering and way-0 priority reachable with a handful of directed addresses. Because the changed bit sits inside the low byte of the entry word, the bench can store entries with the bit clear or set. This exercises the write-miss-then-hit sequence alongside plain read hits on the same kind of entry.

// File: rtl/stlb_pkg.sv
package stlb_pkg;

    localparam int unsigned ADDR_W = 32;
    localparam logic [ADDR_W-1:0] TAG_EMPTY = '1;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_PROBE = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic              match;
        logic              way;
        logic [ADDR_W-1:0] page;
        logic              chg;
    } probe_res_t;

    // 0 selects the instruction-side array, 1 the data-side array
    function automatic logic side_of(input acc_kind_e kind);
        return (kind != ACC_FETCH);
    endfunction

endpackage

// File: rtl/stlb_victim.sv
module stlb_victim (
    input  logic recent,
    input  logic way0_live,
    output logic way
);
    // way 1 only when way 0 is occupied and was the last one touched
    always_comb way = (!recent) && way0_live;
endmodule

// File: rtl/stlb_array.sv
module stlb_array
    import stlb_pkg::*;
#(
    parameter int unsigned PAGE_SHIFT = 12,
    parameter int unsigned SET_BITS   = 6,
    parameter int unsigned CHG_BIT    = 7
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         lk_en,
    input  acc_kind_e                    lk_kind,
    input  logic [ADDR_W-1:0]            lk_va,
    input  logic                         rf_en,
    input  logic [ADDR_W-1:0]            rf_va,
    input  logic [ADDR_W-1:0]            rf_pte,
    input  logic [ADDR_W-PAGE_SHIFT-1:0] rf_rpn,
    input  logic                         inv_en,
    input  logic [SET_BITS-1:0]          inv_set,
    output probe_res_t                   lk_res
);
    localparam int unsigned SETS = 1 << SET_BITS;

    logic [ADDR_W-1:0] tag_q  [SETS][2];
    logic [ADDR_W-1:0] page_q [SETS][2];
    logic [ADDR_W-1:0] pte_q  [SETS][2];
    logic              rec_q  [SETS];

    function automatic logic [SET_BITS-1:0] set_of(input logic [ADDR_W-1:0] va);
        return va[PAGE_SHIFT +: SET_BITS];
    endfunction

    function automatic logic [ADDR_W-1:0] tag_of(input logic [ADDR_W-1:0] va);
        return va >> PAGE_SHIFT;
    endfunction

    // lookup path, reads the state held before this cycle's updates
    logic [SET_BITS-1:0] l_set;
    logic [ADDR_W-1:0]   l_tag;
    logic                m0, m1;

    always_comb begin
        l_set        = set_of(lk_va);
        l_tag        = tag_of(lk_va);
        m0           = (tag_q[l_set][0] == l_tag);
        m1           = (tag_q[l_set][1] == l_tag);
        lk_res.match = m0 | m1;
        lk_res.way   = !m0;
        lk_res.page  = page_q[l_set][lk_res.way];
        lk_res.chg   = pte_q[l_set][lk_res.way][CHG_BIT];
    end

    // refill placement
    logic [SET_BITS-1:0] r_set;
    logic [ADDR_W-1:0]   r_tag;
    logic                r_way;

    always_comb begin
        r_set = set_of(rf_va);
        r_tag = tag_of(rf_va);
    end

    stlb_victim u_victim (
        .recent    (rec_q[r_set]),
        .way0_live (tag_q[r_set][0] != TAG_EMPTY),
        .way       (r_way)
    );

    // later statements win: lookup side effects, then refill, then invalidate
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < int'(SETS); s++) begin
                rec_q[s] <= 1'b0;
                for (int w = 0; w < 2; w++) begin
                    tag_q[s][w]  <= TAG_EMPTY;
                    page_q[s][w] <= '0;
                    pte_q[s][w]  <= '0;
                end
            end
        end else begin
            if (lk_en && lk_res.match) begin
                if (lk_kind == ACC_WRITE && !lk_res.chg)
                    pte_q[l_set][lk_res.way][CHG_BIT] <= 1'b1;
                else if (lk_kind != ACC_PROBE)
                    rec_q[l_set] <= lk_res.way;
            end
            if (rf_en) begin
                tag_q[r_set][r_way]  <= r_tag;
                page_q[r_set][r_way] <= {rf_rpn, {PAGE_SHIFT{1'b0}}};
                pte_q[r_set][r_way]  <= rf_pte;
                rec_q[r_set]         <= r_way;
            end
            if (inv_en) begin
                tag_q[inv_set][0] <= TAG_EMPTY;
                tag_q[inv_set][1] <= TAG_EMPTY;
            end
        end
    end
endmodule

// File: rtl/split_tlb.sv
module split_tlb
    import stlb_pkg::*;
#(
    parameter int unsigned PAGE_SHIFT = 12,
    parameter int unsigned SET_BITS   = 6,
    parameter int unsigned CHG_BIT    = 7
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         lk_valid,
    input  logic [1:0]                   lk_kind,
    input  logic [ADDR_W-1:0]            lk_vaddr,
    input  logic                         rf_valid,
    input  logic [1:0]                   rf_kind,
    input  logic [ADDR_W-1:0]            rf_vaddr,
    input  logic [ADDR_W-1:0]            rf_pte,
    input  logic [ADDR_W-PAGE_SHIFT-1:0] rf_rpn,
    input  logic                         inv_valid,
    input  logic [ADDR_W-1:0]            inv_vaddr,
    output logic                         hit_valid,
    output logic                         hit,
    output logic [ADDR_W-1:0]            hit_paddr
);
    acc_kind_e  lk_k, rf_k;
    logic       lk_side, rf_side, rf_live;
    probe_res_t side_res [2];
    probe_res_t res;
    logic       fin_hit;

    always_comb begin
        lk_k    = acc_kind_e'(lk_kind);
        rf_k    = acc_kind_e'(rf_kind);
        lk_side = side_of(lk_k);
        rf_side = side_of(rf_k);
        rf_live = rf_valid && (rf_k != ACC_PROBE);
    end

    for (genvar g = 0; g < 2; g++) begin : g_side
        stlb_array #(
            .PAGE_SHIFT (PAGE_SHIFT),
            .SET_BITS   (SET_BITS),
            .CHG_BIT    (CHG_BIT)
        ) u_array (
            .clk     (clk),
            .rst     (rst),
            .lk_en   (lk_valid && (lk_side == 1'(g))),
            .lk_kind (lk_k),
            .lk_va   (lk_vaddr),
            .rf_en   (rf_live && (rf_side == 1'(g))),
            .rf_va   (rf_vaddr),
            .rf_pte  (rf_pte),
            .rf_rpn  (rf_rpn),
            .inv_en  (inv_valid),
            .inv_set (inv_vaddr[PAGE_SHIFT +: SET_BITS]),
            .lk_res  (side_res[g])
        );
    end

    always_comb begin
        res     = side_res[lk_side];
        fin_hit = lk_valid && res.match && !(lk_k == ACC_WRITE && !res.chg);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_valid <= 1'b0;
            hit       <= 1'b0;
            hit_paddr <= '0;
        end else begin
            hit_valid <= lk_valid;
            hit       <= fin_hit;
            hit_paddr <= fin_hit ? (res.page | ADDR_W'(lk_vaddr[PAGE_SHIFT-1:0])) : '0;
        end
    end
endmodule

// File: rtl/stlb_checker.sv
module stlb_checker #(
    parameter int unsigned PAGE_SHIFT = 12,
    parameter int unsigned SET_BITS   = 6
) (
    input logic        clk,
    input logic        rst,
    input logic        lk_valid,
    input logic [31:0] lk_vaddr,
    input logic        inv_valid,
    input logic [31:0] inv_vaddr,
    input logic        hit_valid,
    input logic        hit,
    input logic [31:0] hit_paddr
);
    logic armed_q;
    always_ff @(posedge clk) armed_q <= !rst;

    // R2: result appears exactly one cycle after the request
    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        armed_q |-> (hit_valid == $past(lk_valid)));

    // R2: a hit only accompanies a valid result
    p_hit_has_valid_r2: assert property (@(posedge clk) disable iff (rst)
        hit |-> hit_valid);

    // R2: miss carries a zero address
    p_miss_zero_r2: assert property (@(posedge clk) disable iff (rst)
        !hit |-> (hit_paddr == 32'd0));

    // R3: the page offset passes through untouched
    p_offset_r3: assert property (@(posedge clk) disable iff (rst)
        (armed_q && hit) |-> (hit_paddr[PAGE_SHIFT-1:0] == $past(lk_vaddr[PAGE_SHIFT-1:0])));

    // R9: a lookup right after an invalidate of its set misses
    p_inv_miss_r9: assert property (@(posedge clk) disable iff (rst)
        (armed_q && $past(inv_valid) && lk_valid &&
         lk_vaddr[PAGE_SHIFT +: SET_BITS] == $past(inv_vaddr[PAGE_SHIFT +: SET_BITS]))
        |=> !hit);
endmodule

bind split_tlb stlb_checker #(
    .PAGE_SHIFT (PAGE_SHIFT),
    .SET_BITS   (SET_BITS)
) u_stlb_checker (
    .clk       (clk),
    .rst       (rst),
    .lk_valid  (lk_valid),
    .lk_vaddr  (lk_vaddr),
    .inv_valid (inv_valid),
    .inv_vaddr (inv_vaddr),
    .hit_valid (hit_valid),
    .hit       (hit),
    .hit_paddr (hit_paddr)
);

// File: tb/test_split_tlb.sv
module test_split_tlb;
    logic        clk = 1'b0;
    logic        rst;
    logic        lk_valid, rf_valid, inv_valid;
    logic [1:0]  lk_kind, rf_kind;
    logic [31:0] lk_vaddr, rf_vaddr, rf_pte, inv_vaddr;
    logic [19:0] rf_rpn;
    logic        hit_valid, hit;
    logic [31:0] hit_paddr;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    split_tlb #(.PAGE_SHIFT(12), .SET_BITS(6), .CHG_BIT(7)) i_split_tlb (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_kind(lk_kind), .lk_vaddr(lk_vaddr),
        .rf_valid(rf_valid), .rf_kind(rf_kind), .rf_vaddr(rf_vaddr),
        .rf_pte(rf_pte), .rf_rpn(rf_rpn),
        .inv_valid(inv_valid), .inv_vaddr(inv_vaddr),
        .hit_valid(hit_valid), .hit(hit), .hit_paddr(hit_paddr)
    );

    // behavioural reference: [side][set][way]
    logic [31:0] m_tag  [2][64][2];
    logic [31:0] m_page [2][64][2];
    logic [31:0] m_pte  [2][64][2];
    bit          m_rec  [2][64];
    bit          e_v, e_h;
    logic [31:0] e_pa;

    task automatic model_reset();
        for (int a = 0; a < 2; a++)
            for (int s = 0; s < 64; s++) begin
                m_rec[a][s] = 0;
                for (int w = 0; w < 2; w++) begin
                    m_tag[a][s][w] = 32'hFFFF_FFFF;
                    m_page[a][s][w] = 0;
                    m_pte[a][s][w] = 0;
                end
            end
        e_v = 0; e_h = 0; e_pa = 0;
    endtask

    task automatic model_step();
        int ls, lsd, lw, rs, rsd, rw, is;
        bit rf_go;
        e_v = lk_valid; e_h = 0; e_pa = 0;
        rf_go = rf_valid && (rf_kind != 2'd3);
        rs = int'((rf_vaddr >> 12) & 32'h3F);
        rsd = (rf_kind == 2'd0) ? 0 : 1;
        rw = (m_rec[rsd][rs] == 0 && m_tag[rsd][rs][0] != 32'hFFFF_FFFF) ? 1 : 0;
        if (lk_valid) begin
            ls = int'((lk_vaddr >> 12) & 32'h3F);
            lsd = (lk_kind == 2'd0) ? 0 : 1;
            lw = -1;
            if (m_tag[lsd][ls][0] == (lk_vaddr >> 12)) lw = 0;
            else if (m_tag[lsd][ls][1] == (lk_vaddr >> 12)) lw = 1;
            if (lw >= 0) begin
                if (lk_kind == 2'd2 && !m_pte[lsd][ls][lw][7]) begin
                    m_pte[lsd][ls][lw][7] = 1'b1;
                end else begin
                    e_h = 1;
                    e_pa = m_page[lsd][ls][lw] | (lk_vaddr & 32'hFFF);
                    if (lk_kind != 2'd3) m_rec[lsd][ls] = (lw == 1);
                end
            end
        end
        if (rf_go) begin
            m_tag[rsd][rs][rw] = rf_vaddr >> 12;
            m_page[rsd][rs][rw] = {rf_rpn, 12'h000};
            m_pte[rsd][rs][rw] = rf_pte;
            m_rec[rsd][rs] = (rw == 1);
        end
        if (inv_valid) begin
            is = int'((inv_vaddr >> 12) & 32'h3F);
            for (int a = 0; a < 2; a++) begin
                m_tag[a][is][0] = 32'hFFFF_FFFF;
                m_tag[a][is][1] = 32'hFFFF_FFFF;
            end
        end
    endtask

    task automatic check(input string req, input logic [33:0] act, input logic [33:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual {valid,hit,paddr}=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(cur_req, {hit_valid, hit, hit_paddr}, {e_v, e_h, e_pa});
    endtask

    task automatic clr();
        lk_valid = 0; rf_valid = 0; inv_valid = 0;
        lk_kind = 0; rf_kind = 0; lk_vaddr = 0; rf_vaddr = 0;
        rf_pte = 0; rf_rpn = 0; inv_vaddr = 0;
    endtask

    task automatic set_lk(input logic [1:0] k, input logic [31:0] va);
        lk_valid = 1; lk_kind = k; lk_vaddr = va;
    endtask

    task automatic set_rf(input logic [1:0] k, input logic [31:0] va,
                          input logic [19:0] rpn, input logic [31:0] pte);
        rf_valid = 1; rf_kind = k; rf_vaddr = va; rf_rpn = rpn; rf_pte = pte;
    endtask

    task automatic rf(input logic [1:0] k, input logic [31:0] va,
                      input logic [19:0] rpn, input logic [31:0] pte);
        set_rf(k, va, rpn, pte); step(); clr();
    endtask

    // lookup, then compare against a literal expectation as well
    task automatic lk(input string req, input logic [1:0] k, input logic [31:0] va,
                      input bit xh, input logic [31:0] xpa);
        set_lk(k, va); step(); clr();
        check(req, {hit_valid, hit, hit_paddr}, {1'b1, xh, xpa});
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        clr();
        model_reset();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check("R1", {hit_valid, hit, hit_paddr}, 34'd0);

        cur_req = "R1";
        lk("R1", 2'd1, 32'h0000_1234, 0, 0);
        lk("R1", 2'd0, 32'h0000_0000, 0, 0);

        cur_req = "R3";
        rf(2'd1, 32'h0000_3000, 20'hABCDE, 32'h80);
        lk("R3", 2'd1, 32'h0000_3456, 1, 32'hABCD_E456);
        lk("R3", 2'd1, 32'h0004_3456, 0, 0);
        cur_req = "R2";
        step();
        check("R2", {hit_valid, hit, hit_paddr}, 34'd0);

        cur_req = "R4";
        lk("R4", 2'd0, 32'h0000_3456, 0, 0);
        rf(2'd0, 32'h0000_F000, 20'h77777, 32'h80);
        lk("R4", 2'd0, 32'h0000_F00C, 1, 32'h7777_700C);
        lk("R4", 2'd1, 32'h0000_F00C, 0, 0);

        cur_req = "R5";
        rf(2'd1, 32'h0000_5000, 20'h11111, 32'h80);
        rf(2'd1, 32'h0004_5000, 20'h22222, 32'h80);
        rf(2'd1, 32'h0008_5000, 20'h33333, 32'h80);
        lk("R5", 2'd1, 32'h0000_5000, 0, 0);
        lk("R5", 2'd1, 32'h0004_5001, 1, 32'h2222_2001);
        lk("R5", 2'd1, 32'h0008_5002, 1, 32'h3333_3002);

        cur_req = "R6";
        rf(2'd1, 32'h0000_6000, 20'h11111, 32'h80);
        rf(2'd1, 32'h0004_6000, 20'h22222, 32'h80);
        lk("R6", 2'd1, 32'h0000_6000, 1, 32'h1111_1000);
        rf(2'd1, 32'h0008_6000, 20'h33333, 32'h80);
        lk("R6", 2'd1, 32'h0004_6000, 0, 0);
        lk("R6", 2'd1, 32'h0000_6000, 1, 32'h1111_1000);
        rf(2'd1, 32'h0000_7000, 20'h11111, 32'h80);
        rf(2'd1, 32'h0004_7000, 20'h22222, 32'h80);
        lk("R6", 2'd3, 32'h0000_7000, 1, 32'h1111_1000);
        rf(2'd1, 32'h0008_7000, 20'h33333, 32'h80);
        lk("R6", 2'd1, 32'h0000_7000, 0, 0);
        lk("R6", 2'd1, 32'h0004_7000, 1, 32'h2222_2000);

        cur_req = "R7";
        rf(2'd1, 32'h0000_8000, 20'h44444, 32'h0);
        lk("R7", 2'd2, 32'h0000_8010, 0, 0);
        lk("R7", 2'd2, 32'h0000_8010, 1, 32'h4444_4010);
        rf(2'd1, 32'h0000_9000, 20'h45454, 32'h0);
        lk("R7", 2'd1, 32'h0000_9020, 1, 32'h4545_4020);

        cur_req = "R8";
        rf(2'd3, 32'h0000_A000, 20'h12345, 32'h80);
        lk("R8", 2'd1, 32'h0000_A000, 0, 0);
        lk("R8", 2'd3, 32'h0000_A000, 0, 0);

        cur_req = "R9";
        rf(2'd0, 32'h0000_B000, 20'h0000B, 32'h80);
        rf(2'd1, 32'h0000_B000, 20'h1000B, 32'h80);
        rf(2'd1, 32'h0004_B000, 20'h2000B, 32'h80);
        lk("R9", 2'd1, 32'h0004_B000, 1, 32'h2000_B000);
        inv_valid = 1; inv_vaddr = 32'h1234_B777; step(); clr();
        lk("R9", 2'd0, 32'h0000_B000, 0, 0);
        lk("R9", 2'd1, 32'h0000_B000, 0, 0);
        lk("R9", 2'd1, 32'h0004_B000, 0, 0);

        cur_req = "R10";
        set_rf(2'd1, 32'h0000_C000, 20'h0C0C0, 32'h80);
        inv_valid = 1; inv_vaddr = 32'h0000_C000;
        step(); clr();
        lk("R10", 2'd1, 32'h0000_C000, 0, 0);
        set_rf(2'd1, 32'h0000_D000, 20'h0D0D0, 32'h80);
        set_lk(2'd1, 32'h0000_D004);
        step(); clr();
        check("R10", {hit_valid, hit, hit_paddr}, {1'b1, 1'b0, 32'h0});
        lk("R10", 2'd1, 32'h0000_D004, 1, 32'h0D0D_0004);

        cur_req = "R11";
        rf(2'd1, 32'h0000_E000, 20'h55555, 32'h80);
        rf(2'd1, 32'h0000_E000, 20'h66666, 32'h80);
        lk("R11", 2'd1, 32'h0000_E0FF, 1, 32'h5555_50FF);

        step();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule